// File: doc/BRIEF.md
# Banked Exception Acknowledge and Completion Unit

This unit holds the pending, active and enable-qualified state of a numbered set of exceptions in two copies. The non-secure copy has an entry for every exception number. The secure copy has entries only for the numbers that a parameter mask marks as banked. An upstream arbiter picks the exception to take and presents its number, a bank flag and its priority. When the acknowledge strobe arrives, the unit checks that the request is legal. A legal request moves that entry from pending to active, records the number as the exception being handled, and reports whether the handler runs in secure or non-secure state.

When a handler returns, the processor sends a completion request with the exception number and a secure flag. The unit picks the matching copy, clears the active bit and returns a two-bit status. The status says whether the return was illegal, whether other exceptions are still active, or whether the core is back at base level. A small pend-set port lets the surrounding logic raise exceptions in either copy. Per-exception enables and per-exception target-state bits come in as static configuration vectors.

All results are registered. Each strobe gives its result on the outputs after the clock edge that samples it, and the result lasts one cycle.

Top module: `excp_bank_unit`

## Requirements
- R1: Synchronous reset clears every pending and active bit in both copies, sets `cur_exc` to 0 and holds `ack_done`, `ack_err` and `cmp_done` low.
- R2: A pend-set with `pset_secure`=1 on a banked number sets that number's bit in `pend_s`. Any other pend-set for a number in 2..NUM_EXC-1 sets the bit in `pend_ns`. Bits of `pend_s` and `act_s` for unbanked numbers always read 0.
- R3: A legal acknowledge clears the selected pending bit, sets the matching active bit, loads `cur_exc` with the number and pulses `ack_done` for one cycle.
- R4: An acknowledge with `sel_banked`=1 uses the secure copy and reports `ack_secure`=1.
- R5: An acknowledge with `sel_banked`=0 uses the non-secure copy. It reports `ack_secure`=1 only when the number is not banked and its `tgt_secure` bit is 1.
- R6: An acknowledge is illegal when any of these holds: the number is 1 or less, the number is NUM_EXC or more, the entry is not enabled, the entry is not pending, or `sel_prio` is not strictly below `exec_prio`. An illegal acknowledge pulses `ack_err` instead of `ack_done` and leaves every pending and active bit and `cur_exc` unchanged.
- R7: A completion uses the secure copy only when `cmp_secure`=1 and the number is banked. Otherwise it uses the non-secure copy.
- R8: A completion whose selected entry is not active returns status 2'b10 (illegal) and changes no active bit.
- R9: A legal completion clears the selected active bit. It returns 2'b01 when no bit in either active vector remains set, and 2'b00 otherwise. `cmp_done` is a one-cycle pulse that goes with the status.
- R10: When an acknowledge and a completion arrive in the same cycle, the completion is applied first, and the entry activated by that acknowledge counts as still active in the completion status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pset_valid | input | 1 | Pend-set strobe |
| pset_num | input | NUM_W | Exception number to make pending |
| pset_secure | input | 1 | Target the secure copy (banked numbers only) |
| en_ns | input | NUM_EXC | Per-exception enable, non-secure copy |
| en_s | input | NUM_EXC | Per-exception enable, secure copy |
| tgt_secure | input | NUM_EXC | Per-exception target state for unbanked numbers (1 = secure) |
| exec_prio | input | PRIO_W | Current execution priority |
| ack_req | input | 1 | Acknowledge strobe |
| sel_num | input | NUM_W | Selected pending exception number |
| sel_banked | input | 1 | Selection refers to the secure copy |
| sel_prio | input | PRIO_W | Priority of the selection |
| ack_done | output | 1 | Legal acknowledge taken (one-cycle pulse) |
| ack_err | output | 1 | Illegal acknowledge (one-cycle pulse) |
| ack_secure | output | 1 | Handler targets secure state (valid with ack_done) |
| cur_exc | output | NUM_W | Exception currently being handled |
| cmp_req | input | 1 | Completion strobe |
| cmp_num | input | NUM_W | Exception number to complete |
| cmp_secure | input | 1 | Completed exception was secure |
| cmp_done | output | 1 | Completion status valid (one-cycle pulse) |
| cmp_status | output | 2 | 2'b00 still active, 2'b01 back at base, 2'b10 illegal |
| pend_ns | output | NUM_EXC | Pending bits, non-secure copy |
| pend_s | output | NUM_EXC | Pending bits, secure copy |
| act_ns | output | NUM_EXC | Active bits, non-secure copy |
| act_s | output | NUM_EXC | Active bits, secure copy |

## Verification
Every result appears exactly one rising edge after the strobe that caused it. This covers the acknowledge pulses and target flag, `cur_exc`, the completion status, and the pending and active vectors. The bench changes inputs on the falling edge and raises a strobe for exactly one rising edge. It then reads the outputs on the next falling edge, so each check lands in the single cycle in which a pulse is valid. One extra check, a cycle later, confirms that `cmp_done` has dropped again, and the same-cycle case drives both strobes on the same falling edge.

// File: rtl/excp_pkg.sv
package excp_pkg;

  typedef enum logic [1:0] {
    ST_STILL_ACTIVE = 2'b00,
    ST_TO_BASE      = 2'b01,
    ST_ILLEGAL      = 2'b10
  } cmp_status_e;

  // Lowest number an acknowledge or completion may name is RESET_EXC + 1.
  localparam int unsigned RESET_EXC = 1;

endpackage

// File: rtl/excp_bank_store.sv
module excp_bank_store #(
  parameter int unsigned        NUM     = 24,
  parameter logic [NUM-1:0]     PRESENT = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_pend,
  input  logic [NUM-1:0] clr_pend,
  input  logic [NUM-1:0] set_act,
  input  logic [NUM-1:0] clr_act,
  output logic [NUM-1:0] pend,
  output logic [NUM-1:0] act
);

  // Clear is applied before set, so a same-cycle set survives.
  for (genvar i = 0; i < NUM; i++) begin : g_entry
    if (PRESENT[i]) begin : g_bit
      logic pend_q;
      logic act_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= 1'b0;
          act_q  <= 1'b0;
        end else begin
          pend_q <= (pend_q & ~clr_pend[i]) | set_pend[i];
          act_q  <= (act_q & ~clr_act[i]) | set_act[i];
        end
      end
      assign pend[i] = pend_q;
      assign act[i]  = act_q;
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{set_pend[i], clr_pend[i], set_act[i], clr_act[i]};
      assign pend[i]   = 1'b0;
      assign act[i]    = 1'b0;
    end
  end

endmodule

// File: rtl/excp_ack_ctrl.sv
module excp_ack_ctrl
  import excp_pkg::*;
#(
  parameter int unsigned    NUM    = 24,
  parameter int unsigned    NUM_W  = 5,
  parameter int unsigned    PRIO_W = 8,
  parameter logic [NUM-1:0] BANKED = '0
) (
  input  logic              req,
  input  logic [NUM_W-1:0]  sel_num,
  input  logic              sel_banked,
  input  logic [PRIO_W-1:0] sel_prio,
  input  logic [PRIO_W-1:0] exec_prio,
  input  logic [NUM-1:0]    en_ns,
  input  logic [NUM-1:0]    en_s,
  input  logic [NUM-1:0]    pend_ns,
  input  logic [NUM-1:0]    pend_s,
  input  logic [NUM-1:0]    tgt_secure,
  output logic              legal,
  output logic              to_secure,
  output logic [NUM-1:0]    take_ns,
  output logic [NUM-1:0]    take_s
);

  logic           in_range;
  logic           entry_en;
  logic           entry_pend;
  logic           num_banked;
  logic           cfg_sec;
  logic [NUM-1:0] sel_bit;

  assign in_range = (32'(sel_num) > RESET_EXC) && (32'(sel_num) < NUM);
  assign sel_bit  = NUM'(1) << sel_num;

  always_comb begin
    entry_en   = 1'b0;
    entry_pend = 1'b0;
    num_banked = 1'b0;
    cfg_sec    = 1'b0;
    if (in_range) begin
      entry_en   = sel_banked ? en_s[sel_num]   : en_ns[sel_num];
      entry_pend = sel_banked ? pend_s[sel_num] : pend_ns[sel_num];
      num_banked = BANKED[sel_num];
      cfg_sec    = tgt_secure[sel_num];
    end
  end

  assign legal     = req && in_range && entry_en && entry_pend && (sel_prio < exec_prio);
  assign to_secure = sel_banked || (!num_banked && cfg_sec);
  assign take_ns   = (legal && !sel_banked) ? sel_bit : '0;
  assign take_s    = (legal &&  sel_banked) ? sel_bit : '0;

endmodule

// File: rtl/excp_cmp_ctrl.sv
module excp_cmp_ctrl
  import excp_pkg::*;
#(
  parameter int unsigned    NUM    = 24,
  parameter int unsigned    NUM_W  = 5,
  parameter logic [NUM-1:0] BANKED = '0
) (
  input  logic             req,
  input  logic [NUM_W-1:0] num,
  input  logic             secure,
  input  logic [NUM-1:0]   act_ns,
  input  logic [NUM-1:0]   act_s,
  input  logic [NUM-1:0]   ack_set_ns,
  input  logic [NUM-1:0]   ack_set_s,
  output logic             hit,
  output logic [NUM-1:0]   clr_ns,
  output logic [NUM-1:0]   clr_s,
  output cmp_status_e      status
);

  logic           in_range;
  logic           use_s;
  logic           entry_act;
  logic           remain;
  logic [NUM-1:0] num_bit;

  assign in_range = (32'(num) > RESET_EXC) && (32'(num) < NUM);
  assign num_bit  = NUM'(1) << num;

  always_comb begin
    use_s     = 1'b0;
    entry_act = 1'b0;
    if (in_range) begin
      use_s     = secure && BANKED[num];
      entry_act = use_s ? act_s[num] : act_ns[num];
    end
  end

  assign hit    = req && entry_act;
  assign clr_ns = (hit && !use_s) ? num_bit : '0;
  assign clr_s  = (hit &&  use_s) ? num_bit : '0;

  // Completion is applied first; a same-cycle acknowledge still counts.
  assign remain = (|((act_ns & ~clr_ns) | ack_set_ns)) ||
                  (|((act_s  & ~clr_s)  | ack_set_s));

  always_comb begin
    if (!hit)        status = ST_ILLEGAL;
    else if (remain) status = ST_STILL_ACTIVE;
    else             status = ST_TO_BASE;
  end

endmodule

// File: rtl/excp_bank_unit.sv
module excp_bank_unit
  import excp_pkg::*;
#(
  parameter int unsigned        NUM_EXC     = 24,
  parameter int unsigned        PRIO_W      = 8,
  parameter logic [NUM_EXC-1:0] BANKED_MASK = 24'h00006C,
  localparam int unsigned       NUM_W       = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pset_valid,
  input  logic [NUM_W-1:0]   pset_num,
  input  logic               pset_secure,
  input  logic [NUM_EXC-1:0] en_ns,
  input  logic [NUM_EXC-1:0] en_s,
  input  logic [NUM_EXC-1:0] tgt_secure,
  input  logic [PRIO_W-1:0]  exec_prio,
  input  logic               ack_req,
  input  logic [NUM_W-1:0]   sel_num,
  input  logic               sel_banked,
  input  logic [PRIO_W-1:0]  sel_prio,
  output logic               ack_done,
  output logic               ack_err,
  output logic               ack_secure,
  output logic [NUM_W-1:0]   cur_exc,
  input  logic               cmp_req,
  input  logic [NUM_W-1:0]   cmp_num,
  input  logic               cmp_secure,
  output logic               cmp_done,
  output logic [1:0]         cmp_status,
  output logic [NUM_EXC-1:0] pend_ns,
  output logic [NUM_EXC-1:0] pend_s,
  output logic [NUM_EXC-1:0] act_ns,
  output logic [NUM_EXC-1:0] act_s
);

  logic               pset_ok;
  logic               pset_to_s;
  logic [NUM_EXC-1:0] pset_bit;
  logic [NUM_EXC-1:0] pset_ns_v;
  logic [NUM_EXC-1:0] pset_s_v;

  assign pset_ok   = pset_valid && (32'(pset_num) > RESET_EXC) && (32'(pset_num) < NUM_EXC);
  assign pset_to_s = pset_ok && pset_secure && BANKED_MASK[pset_num];
  assign pset_bit  = NUM_EXC'(1) << pset_num;
  assign pset_ns_v = (pset_ok && !pset_to_s) ? pset_bit : '0;
  assign pset_s_v  = pset_to_s ? pset_bit : '0;

  logic               ack_legal;
  logic               ack_to_sec;
  logic [NUM_EXC-1:0] take_ns;
  logic [NUM_EXC-1:0] take_s;

  excp_ack_ctrl #(
    .NUM    (NUM_EXC),
    .NUM_W  (NUM_W),
    .PRIO_W (PRIO_W),
    .BANKED (BANKED_MASK)
  ) i_ack (
    .req        (ack_req),
    .sel_num    (sel_num),
    .sel_banked (sel_banked),
    .sel_prio   (sel_prio),
    .exec_prio  (exec_prio),
    .en_ns      (en_ns),
    .en_s       (en_s),
    .pend_ns    (pend_ns),
    .pend_s     (pend_s),
    .tgt_secure (tgt_secure),
    .legal      (ack_legal),
    .to_secure  (ack_to_sec),
    .take_ns    (take_ns),
    .take_s     (take_s)
  );

  logic               cmp_hit;
  logic [NUM_EXC-1:0] cmp_clr_ns;
  logic [NUM_EXC-1:0] cmp_clr_s;
  cmp_status_e        cmp_stat;

  excp_cmp_ctrl #(
    .NUM    (NUM_EXC),
    .NUM_W  (NUM_W),
    .BANKED (BANKED_MASK)
  ) i_cmp (
    .req        (cmp_req),
    .num        (cmp_num),
    .secure     (cmp_secure),
    .act_ns     (act_ns),
    .act_s      (act_s),
    .ack_set_ns (take_ns),
    .ack_set_s  (take_s),
    .hit        (cmp_hit),
    .clr_ns     (cmp_clr_ns),
    .clr_s      (cmp_clr_s),
    .status     (cmp_stat)
  );

  excp_bank_store #(
    .NUM     (NUM_EXC),
    .PRESENT ({NUM_EXC{1'b1}})
  ) i_bank_ns (
    .clk      (clk),
    .rst      (rst),
    .set_pend (pset_ns_v),
    .clr_pend (take_ns),
    .set_act  (take_ns),
    .clr_act  (cmp_clr_ns),
    .pend     (pend_ns),
    .act      (act_ns)
  );

  excp_bank_store #(
    .NUM     (NUM_EXC),
    .PRESENT (BANKED_MASK)
  ) i_bank_s (
    .clk      (clk),
    .rst      (rst),
    .set_pend (pset_s_v),
    .clr_pend (take_s),
    .set_act  (take_s),
    .clr_act  (cmp_clr_s),
    .pend     (pend_s),
    .act      (act_s)
  );

  logic unused_hit;
  assign unused_hit = cmp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_done   <= 1'b0;
      ack_err    <= 1'b0;
      ack_secure <= 1'b0;
      cur_exc    <= '0;
      cmp_done   <= 1'b0;
      cmp_status <= 2'b00;
    end else begin
      ack_done   <= ack_legal;
      ack_err    <= ack_req && !ack_legal;
      ack_secure <= ack_legal && ack_to_sec;
      if (ack_legal) cur_exc <= sel_num;
      cmp_done   <= cmp_req;
      cmp_status <= cmp_req ? cmp_stat : 2'b00;
    end
  end

endmodule

// File: rtl/excp_bank_unit_chk.sv
module excp_bank_unit_chk #(
  parameter int unsigned  NUM_EXC = 24,
  localparam int unsigned NUM_W   = $clog2(NUM_EXC)
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_done,
  input logic               ack_err,
  input logic [NUM_W-1:0]   cur_exc,
  input logic               cmp_done,
  input logic [1:0]         cmp_status,
  input logic [NUM_EXC-1:0] pend_ns,
  input logic [NUM_EXC-1:0] pend_s,
  input logic [NUM_EXC-1:0] act_ns,
  input logic [NUM_EXC-1:0] act_s
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_ns == '0 && pend_s == '0 && act_ns == '0 && act_s == '0 &&
                    cur_exc == '0 && !ack_done && !ack_err && !cmp_done));

  assert_ack_active_R3: assert property (@(posedge clk) disable iff (rst)
    ack_done |-> (act_ns[cur_exc] || act_s[cur_exc]));

  assert_ack_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(ack_done && ack_err));

  assert_ack_err_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_err && !cmp_done) |-> ($stable(act_ns) && $stable(act_s) && $stable(cur_exc)));

  assert_illegal_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_status == 2'b10 && !ack_done) |-> ($stable(act_ns) && $stable(act_s)));

  assert_base_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_status == 2'b01) |-> (act_ns == '0 && act_s == '0));

  assert_still_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && cmp_status == 2'b00) |-> ((act_ns | act_s) != '0));

  assert_status_code_R9: assert property (@(posedge clk) disable iff (rst)
    cmp_done |-> (cmp_status != 2'b11));

endmodule

bind excp_bank_unit excp_bank_unit_chk #(.NUM_EXC(NUM_EXC)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .ack_done   (ack_done),
  .ack_err    (ack_err),
  .cur_exc    (cur_exc),
  .cmp_done   (cmp_done),
  .cmp_status (cmp_status),
  .pend_ns    (pend_ns),
  .pend_s     (pend_s),
  .act_ns     (act_ns),
  .act_s      (act_s)
);

// File: tb/test_excp_bank_unit.sv
`timescale 1ns/1ps
module test_excp_bank_unit;

  localparam int unsigned NUM   = 24;
  localparam int unsigned NW    = 5;
  localparam logic [NUM-1:0] MASK = 24'h00006C;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pset_valid = 1'b0;
  logic [NW-1:0]  pset_num = '0;
  logic           pset_secure = 1'b0;
  logic [NUM-1:0] en_ns = '1;
  logic [NUM-1:0] en_s = '1;
  logic [NUM-1:0] tgt_secure = 24'h000090;
  logic [7:0]     exec_prio = 8'h80;
  logic           ack_req = 1'b0;
  logic [NW-1:0]  sel_num = '0;
  logic           sel_banked = 1'b0;
  logic [7:0]     sel_prio = '0;
  logic           ack_done, ack_err, ack_secure;
  logic [NW-1:0]  cur_exc;
  logic           cmp_req = 1'b0;
  logic [NW-1:0]  cmp_num = '0;
  logic           cmp_secure = 1'b0;
  logic           cmp_done;
  logic [1:0]     cmp_status;
  logic [NUM-1:0] pend_ns, pend_s, act_ns, act_s;

  always #10 clk = ~clk;

  excp_bank_unit i_excp_bank_unit (
    .clk(clk), .rst(rst),
    .pset_valid(pset_valid), .pset_num(pset_num), .pset_secure(pset_secure),
    .en_ns(en_ns), .en_s(en_s), .tgt_secure(tgt_secure), .exec_prio(exec_prio),
    .ack_req(ack_req), .sel_num(sel_num), .sel_banked(sel_banked), .sel_prio(sel_prio),
    .ack_done(ack_done), .ack_err(ack_err), .ack_secure(ack_secure), .cur_exc(cur_exc),
    .cmp_req(cmp_req), .cmp_num(cmp_num), .cmp_secure(cmp_secure),
    .cmp_done(cmp_done), .cmp_status(cmp_status),
    .pend_ns(pend_ns), .pend_s(pend_s), .act_ns(act_ns), .act_s(act_s)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // Advance to the next falling edge; strobes were seen by exactly one rising edge.
  task automatic tick();
    @(negedge clk);
    pset_valid = 1'b0;
    ack_req    = 1'b0;
    cmp_req    = 1'b0;
  endtask

  // op: 0 pend-set, 1 acknowledge, 2 completion
  // exp: pend-set -> bit0 = bank (1 secure); ack -> {err, secure}; completion -> status
  typedef struct packed {
    logic [1:0] op;
    logic [4:0] num;
    logic       flag;
    logic [7:0] prio;
    logic [1:0] exp;
  } step_t;

  localparam step_t TBL [0:16] = '{
    '{2'd0, 5'd5, 1'b1, 8'h00, 2'b01},
    '{2'd0, 5'd5, 1'b0, 8'h00, 2'b00},
    '{2'd0, 5'd4, 1'b1, 8'h00, 2'b00},
    '{2'd0, 5'd7, 1'b0, 8'h00, 2'b00},
    '{2'd1, 5'd5, 1'b1, 8'h0A, 2'b01},
    '{2'd1, 5'd5, 1'b0, 8'h0A, 2'b00},
    '{2'd1, 5'd4, 1'b0, 8'h0A, 2'b01},
    '{2'd1, 5'd7, 1'b0, 8'h90, 2'b10},
    '{2'd1, 5'd7, 1'b0, 8'h80, 2'b10},
    '{2'd1, 5'd7, 1'b0, 8'h7F, 2'b01},
    '{2'd1, 5'd9, 1'b0, 8'h01, 2'b10},
    '{2'd2, 5'd4, 1'b1, 8'h00, 2'b00},
    '{2'd2, 5'd5, 1'b1, 8'h00, 2'b00},
    '{2'd2, 5'd5, 1'b1, 8'h00, 2'b10},
    '{2'd2, 5'd7, 1'b0, 8'h00, 2'b00},
    '{2'd2, 5'd5, 1'b0, 8'h00, 2'b01},
    '{2'd2, 5'd2, 1'b0, 8'h00, 2'b10}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pend_ns", pend_ns, 0);
    chk("R1 pend_s", pend_s, 0);
    chk("R1 act", act_ns | act_s, 0);
    chk("R1 cur_exc", cur_exc, 0);
    chk("R1 pulses", {ack_done, ack_err, cmp_done}, 0);

    for (int k = 0; k < 17; k++) begin
      case (TBL[k].op)
        2'd0: begin
          pset_valid = 1'b1; pset_num = TBL[k].num; pset_secure = TBL[k].flag;
        end
        2'd1: begin
          ack_req = 1'b1; sel_num = TBL[k].num; sel_banked = TBL[k].flag; sel_prio = TBL[k].prio;
        end
        default: begin
          cmp_req = 1'b1; cmp_num = TBL[k].num; cmp_secure = TBL[k].flag;
        end
      endcase
      tick();
      case (TBL[k].op)
        2'd0: begin
          if (TBL[k].exp[0]) chk("R2 pend_s bit", pend_s[TBL[k].num], 1);
          else               chk("R2 pend_ns bit", pend_ns[TBL[k].num], 1);
        end
        2'd1: begin
          if (TBL[k].exp[1]) begin
            chk("R6 ack_err", ack_err, 1);
            chk("R6 no ack_done", ack_done, 0);
          end else begin
            chk("R3 ack_done", ack_done, 1);
            chk("R3 cur_exc", cur_exc, TBL[k].num);
            if (TBL[k].flag) begin
              chk("R4 ack_secure", ack_secure, TBL[k].exp[0]);
              chk("R4 act_s bit", act_s[TBL[k].num], 1);
              chk("R3 pend_s cleared", pend_s[TBL[k].num], 0);
            end else begin
              chk("R5 ack_secure", ack_secure, TBL[k].exp[0]);
              chk("R5 act_ns bit", act_ns[TBL[k].num], 1);
              chk("R3 pend_ns cleared", pend_ns[TBL[k].num], 0);
            end
          end
        end
        default: begin
          chk("R9 cmp_done", cmp_done, 1);
          if (TBL[k].exp == 2'b10)  chk("R8 status", cmp_status, TBL[k].exp);
          else if (TBL[k].flag)     chk("R7 status", cmp_status, TBL[k].exp);
          else                      chk("R9 status", cmp_status, TBL[k].exp);
        end
      endcase
    end

    // R2: no secure storage for unbanked numbers (secure pend-set on 4 went to the non-secure copy)
    chk("R2 pend_s unbanked", pend_s & ~MASK, 0);
    chk("R2 act_s unbanked", act_s & ~MASK, 0);

    // R6: disabled secure entry cannot be acknowledged
    pset_valid = 1'b1; pset_num = 5'd6; pset_secure = 1'b1;
    tick();
    en_s[6] = 1'b0;
    ack_req = 1'b1; sel_num = 5'd6; sel_banked = 1'b1; sel_prio = 8'h01;
    tick();
    chk("R6 disabled err", ack_err, 1);
    chk("R6 disabled pend kept", pend_s[6], 1);
    chk("R6 disabled act kept", act_s[6], 0);
    en_s[6] = 1'b1;
    ack_req = 1'b1; sel_num = 5'd6; sel_banked = 1'b1; sel_prio = 8'h01;
    tick();
    chk("R4 enabled ack", {ack_done, ack_secure, act_s[6]}, 3'b111);

    // R6: number range limits
    ack_req = 1'b1; sel_num = 5'd1; sel_banked = 1'b0; sel_prio = 8'h01;
    tick();
    chk("R6 low number", {ack_err, ack_done}, 2'b10);
    ack_req = 1'b1; sel_num = 5'd24;
    tick();
    chk("R6 high number", {ack_err, ack_done}, 2'b10);
    chk("R6 cur_exc kept", cur_exc, 6);

    // R10: completion and acknowledge in the same cycle
    pset_valid = 1'b1; pset_num = 5'd3; pset_secure = 1'b0;
    tick();
    cmp_req = 1'b1; cmp_num = 5'd6; cmp_secure = 1'b1;
    ack_req = 1'b1; sel_num = 5'd3; sel_banked = 1'b0; sel_prio = 8'h01;
    tick();
    chk("R10 status", cmp_status, 2'b00);
    chk("R10 ack_done", ack_done, 1);
    chk("R10 act_s", act_s, 0);
    chk("R10 act_ns", act_ns, 24'h000008);

    // R7/R8: secure completion of banked 3 finds the secure copy idle
    cmp_req = 1'b1; cmp_num = 5'd3; cmp_secure = 1'b1;
    tick();
    chk("R8 illegal status", cmp_status, 2'b10);
    chk("R7 ns entry kept", act_ns, 24'h000008);

    // R9: last completion returns to base, then the pulse drops
    cmp_req = 1'b1; cmp_num = 5'd3; cmp_secure = 1'b0;
    tick();
    chk("R9 to base", {cmp_done, cmp_status}, 3'b101);
    tick();
    chk("R9 done pulse", cmp_done, 0);

    // R1: reset in mid-operation
    pset_valid = 1'b1; pset_num = 5'd2; pset_secure = 1'b1;
    tick();
    ack_req = 1'b1; sel_num = 5'd2; sel_banked = 1'b1; sel_prio = 8'h01;
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset act", act_ns | act_s | pend_ns | pend_s, 0);
    chk("R1 reset cur_exc", cur_exc, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule